// File: doc/BRIEF.md
# Serially Programmed Sub-Audible Tone Generator

This block produces a continuous square-wave squelch tone for a radio transmitter. The tone is one of 38 standard sub-audible frequencies, picked by a 6-bit tone number. A controller sends that number over a three-wire serial link: a data line, a shift clock and a latch strobe. The block then divides its reference clock, nominally 3.579545 MHz, down to the chosen frequency. Each half period is counted by a reloading down-counter whose start value comes from a table that is built at elaboration time.

A keyed burst mode takes over while the tone key input is held. The output then carries a fixed 1750 Hz square wave, and the active-low transmit request is pulled low in the same clock cycle that the burst starts, which forces the radio into transmit. All serial and key inputs are sampled in the reference clock domain through a synchronizer chain. Output filtering, level trimming and modulation are handled elsewhere.

Top module: `subtone_gen`

## Requirements
- R1: Each rising edge of `serClk` shifts `serData` into a 6-bit register, so the first bit sent ends up as the MSB. A rising edge of `serLatch` makes those 6 bits the new tone number. Tone number n selects the n-th entry of the ascending list 67.0, 71.9, 74.4, 77.0, 79.7, 82.5, 85.4, 88.5, 91.5, 94.8, 97.4, 100.0, 103.5, 107.2, 110.9, 114.8, 118.8, 123.0, 127.3, 131.8, 136.5, 141.3, 146.2, 151.4, 156.7, 162.2, 167.9, 173.8, 179.9, 186.2, 192.8, 203.5, 210.7, 218.1, 225.7, 233.6, 241.8, 250.3 Hz.
- R2: For a tone of f Hz, every high phase and every low phase of `toneOut` lasts round(REF_HZ / (2·f)) clock cycles.
- R3: `toneOut` changes level only when the half-period counter expires, or when a burst starts or ends.
- R4: Tone number 0 and any tone number above 38 stop the counter and hold `toneOut` low.
- R5: A tone number latched while a tone is running takes effect at the next half-period boundary. The half period in progress finishes at its old length, so no runt pulse appears.
- R6: While the synchronized `toneKey` is high, `toneOut` is a square wave with half period round(REF_HZ / 3500) cycles, and `sendN` is low. `sendN` is high at all other times.
- R7: Pressing or releasing the key restarts the counter with `toneOut` low. On release, a tone number latched during the burst becomes active immediately.
- R8: A synchronous active-high `rst` clears the tone number to 0, stops the counter, drives `toneOut` low and drives `sendN` high.
- R9: When the generator is stopped, a newly latched valid tone number starts the tone at once. The first high level then appears one half period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (nominally 3.579545 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| serData | input | 1 | Serial tone-number data |
| serClk | input | 1 | Serial shift clock, sampled on its rising edge |
| serLatch | input | 1 | Latch strobe, rising edge loads the tone number |
| toneKey | input | 1 | Burst key, active high |
| toneOut | output | 1 | Square-wave tone output |
| sendN | output | 1 | Active-low transmit request |

## Verification
Four properties are checked on every cycle:
- a low `sendN` always comes with a counter inside the burst half-period range;
- the output is held low whenever an invalid tone is active outside a burst;
- the output only changes level at counter expiry or at a burst transition;
- the counter never exceeds the longest table entry.

Some behaviour can only be shown by the bench's scenarios:
- the actual half-period lengths for specific tone numbers;
- the MSB-first bit order;
- the absence of a runt when the tone changes mid-period;
- a tone latched during a burst being applied at release.

// File: rtl/subtone_pkg.sv
package subtone_pkg;

  localparam int TONE_CODE_W  = 6;
  localparam int NUM_TONES    = 38;
  localparam int BURST_TENTHS = 17500;

  typedef struct packed {
    logic                   latch;
    logic                   restart;
    logic                   burst;
    logic [TONE_CODE_W-1:0] code;
  } ctrl_t;

  // Tone frequency in tenths of a hertz for a tone number, 0 when unused.
  function automatic int toneTenths(input int idx);
    case (idx)
      1:  return 670;   2:  return 719;   3:  return 744;   4:  return 770;
      5:  return 797;   6:  return 825;   7:  return 854;   8:  return 885;
      9:  return 915;   10: return 948;   11: return 974;   12: return 1000;
      13: return 1035;  14: return 1072;  15: return 1109;  16: return 1148;
      17: return 1188;  18: return 1230;  19: return 1273;  20: return 1318;
      21: return 1365;  22: return 1413;  23: return 1462;  24: return 1514;
      25: return 1567;  26: return 1622;  27: return 1679;  28: return 1738;
      29: return 1799;  30: return 1862;  31: return 1928;  32: return 2035;
      33: return 2107;  34: return 2181;  35: return 2257;  36: return 2336;
      37: return 2418;  38: return 2503;
      default: return 0;
    endcase
  endfunction

  // Rounded half-period count in reference cycles.
  function automatic int halfCount(input int refHz, input int tenths);
    return (refHz * 10 + tenths) / (2 * tenths);
  endfunction

  function automatic int cntWidth(input int refHz);
    return $clog2(halfCount(refHz, toneTenths(1)) + 1);
  endfunction

  function automatic logic codeOk(input logic [TONE_CODE_W-1:0] code);
    return (code != '0) && (int'(code) <= NUM_TONES);
  endfunction

endpackage

// File: rtl/subtone_ctrl.sv
module subtone_ctrl
  import subtone_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  serData,
  input  logic  serClk,
  input  logic  serLatch,
  input  logic  toneKey,
  output ctrl_t strobe
);

  localparam int NIN = 4;
  localparam int IDX_DATA  = 0;
  localparam int IDX_CLK   = 1;
  localparam int IDX_LATCH = 2;
  localparam int IDX_KEY   = 3;

  logic [NIN-1:0]         syncPipe [SYNC_STAGES];
  logic [NIN-1:0]         syncPrev;
  logic [NIN-1:0]         syncCur;
  logic [TONE_CODE_W-1:0] shiftReg;
  logic                   clkRise;

  assign syncCur = syncPipe[SYNC_STAGES-1];
  assign clkRise = syncCur[IDX_CLK] & ~syncPrev[IDX_CLK];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncPipe[i] <= '0;
      syncPrev <= '0;
      shiftReg <= '0;
    end else begin
      syncPipe[0] <= {toneKey, serLatch, serClk, serData};
      for (int i = 1; i < SYNC_STAGES; i++) syncPipe[i] <= syncPipe[i-1];
      syncPrev <= syncCur;
      if (clkRise) shiftReg <= {shiftReg[TONE_CODE_W-2:0], syncCur[IDX_DATA]};
    end
  end

  always_comb begin
    strobe.latch   = syncCur[IDX_LATCH] & ~syncPrev[IDX_LATCH];
    strobe.restart = syncCur[IDX_KEY] ^ syncPrev[IDX_KEY];
    strobe.burst   = syncCur[IDX_KEY];
    strobe.code    = shiftReg;
  end

endmodule

// File: rtl/subtone_dp.sv
module subtone_dp
  import subtone_pkg::*;
#(
  parameter int REF_HZ = 3579545
) (
  input  logic                          clk,
  input  logic                          rst,
  input  ctrl_t                         strobe,
  output logic                          toneOut,
  output logic                          sendN,
  output logic [cntWidth(REF_HZ)-1:0]   cntOut,
  output logic [TONE_CODE_W-1:0]        codeOut
);

  localparam int CNT_W      = cntWidth(REF_HZ);
  localparam int BURST_HALF = halfCount(REF_HZ, BURST_TENTHS);
  localparam int ROM_DEPTH  = 1 << TONE_CODE_W;

  logic [CNT_W-1:0]       halfRom [ROM_DEPTH];
  logic [CNT_W-1:0]       cnt;
  logic [TONE_CODE_W-1:0] activeCode;
  logic [TONE_CODE_W-1:0] pendCode;
  logic                   pendValid;
  logic                   running;

  // Half-period table, folded to constants at elaboration.
  for (genvar g = 0; g < ROM_DEPTH; g++) begin : g_rom
    if (g >= 1 && g <= NUM_TONES) begin : g_used
      assign halfRom[g] = CNT_W'(halfCount(REF_HZ, toneTenths(g)));
    end else begin : g_unused
      assign halfRom[g] = '0;
    end
  end

  logic [TONE_CODE_W-1:0] candCode;
  logic                   candNew;
  logic                   candValid;
  logic [CNT_W-1:0]       candLoad;
  logic [CNT_W-1:0]       burstLoad;

  always_comb begin
    candCode  = strobe.latch ? strobe.code : (pendValid ? pendCode : activeCode);
    candNew   = strobe.latch | pendValid;
    candValid = codeOk(candCode);
    candLoad  = halfRom[candCode] - CNT_W'(1);
    burstLoad = CNT_W'(BURST_HALF - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      activeCode <= '0;
      pendCode   <= '0;
      pendValid  <= 1'b0;
      cnt        <= '0;
      running    <= 1'b0;
      toneOut    <= 1'b0;
      sendN      <= 1'b1;
    end else begin
      sendN <= ~strobe.burst;
      if (strobe.latch) begin
        pendCode  <= strobe.code;
        pendValid <= 1'b1;
      end
      if (strobe.restart) begin
        toneOut <= 1'b0;
        if (strobe.burst) begin
          running <= 1'b1;
          cnt     <= burstLoad;
        end else begin
          activeCode <= candCode;
          pendValid  <= 1'b0;
          running    <= candValid;
          cnt        <= candValid ? candLoad : '0;
        end
      end else if (!running) begin
        if (candNew) begin
          activeCode <= candCode;
          pendValid  <= 1'b0;
          running    <= candValid;
          cnt        <= candValid ? candLoad : '0;
          toneOut    <= 1'b0;
        end
      end else if (cnt == '0) begin
        if (strobe.burst) begin
          cnt     <= burstLoad;
          toneOut <= ~toneOut;
        end else begin
          activeCode <= candCode;
          pendValid  <= 1'b0;
          if (candValid) begin
            cnt     <= candLoad;
            toneOut <= ~toneOut;
          end else begin
            running <= 1'b0;
            toneOut <= 1'b0;
          end
        end
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  assign cntOut  = cnt;
  assign codeOut = activeCode;

endmodule

// File: rtl/subtone_gen.sv
module subtone_gen
  import subtone_pkg::*;
#(
  parameter int REF_HZ      = 3579545,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic serData,
  input  logic serClk,
  input  logic serLatch,
  input  logic toneKey,
  output logic toneOut,
  output logic sendN
);

  localparam int CNT_W      = cntWidth(REF_HZ);
  localparam int MAX_HALF   = halfCount(REF_HZ, toneTenths(1));
  localparam int BURST_HALF = halfCount(REF_HZ, BURST_TENTHS);

  ctrl_t                  ctrlStrobe;
  logic [CNT_W-1:0]       dpCnt;
  logic [TONE_CODE_W-1:0] dpCode;

  subtone_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .serData  (serData),
    .serClk   (serClk),
    .serLatch (serLatch),
    .toneKey  (toneKey),
    .strobe   (ctrlStrobe)
  );

  subtone_dp #(.REF_HZ(REF_HZ)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (ctrlStrobe),
    .toneOut (toneOut),
    .sendN   (sendN),
    .cntOut  (dpCnt),
    .codeOut (dpCode)
  );

endmodule

// File: rtl/subtone_chk.sv
module subtone_chk
  import subtone_pkg::*;
#(
  parameter int CNT_W      = 15,
  parameter int MAX_HALF   = 26713,
  parameter int BURST_HALF = 1023
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   toneOut,
  input logic                   sendN,
  input logic [CNT_W-1:0]       dpCnt,
  input logic [TONE_CODE_W-1:0] dpCode
);

  // R6: a low transmit request only exists while the counter runs the burst period
  a_r6_send_low_burst_count: assert property (@(posedge clk) disable iff (rst)
    !sendN |-> (int'(dpCnt) < BURST_HALF));

  // R4: invalid active tone outside a burst keeps the output low
  a_r4_invalid_code_low: assert property (@(posedge clk) disable iff (rst)
    (sendN && (dpCode == '0 || int'(dpCode) > NUM_TONES)) |-> !toneOut);

  // R3: level changes only at counter expiry or at a burst transition
  a_r3_toggle_at_expiry: assert property (@(posedge clk) disable iff (rst)
    (toneOut != $past(toneOut)) |-> ($past(dpCnt) == '0 || sendN != $past(sendN)));

  // R8: cycle after reset shows the cleared state
  a_r8_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!toneOut && sendN && dpCode == '0));

  // R2: counter never exceeds the longest half period
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    int'(dpCnt) < MAX_HALF);

endmodule

bind subtone_gen subtone_chk #(
  .CNT_W(CNT_W), .MAX_HALF(MAX_HALF), .BURST_HALF(BURST_HALF)
) u_chk (
  .clk(clk), .rst(rst), .toneOut(toneOut), .sendN(sendN),
  .dpCnt(dpCnt), .dpCode(dpCode)
);

// File: tb/subtone_gen_tb.sv
module subtone_gen_tb;

  localparam int REF = 35795;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serData = 1'b0, serClk = 1'b0, serLatch = 1'b0, toneKey = 1'b0;
  logic toneOut, sendN;

  int tests = 0;
  int fails = 0;
  int expQ[$];
  string expTag[$];

  int freqT[38] = '{670, 719, 744, 770, 797, 825, 854, 885, 915, 948, 974, 1000,
                    1035, 1072, 1109, 1148, 1188, 1230, 1273, 1318, 1365, 1413,
                    1462, 1514, 1567, 1622, 1679, 1738, 1799, 1862, 1928, 2035,
                    2107, 2181, 2257, 2336, 2418, 2503};

  always #10 clk = ~clk;

  subtone_gen #(.REF_HZ(REF)) u_dut (
    .clk(clk), .rst(rst), .serData(serData), .serClk(serClk),
    .serLatch(serLatch), .toneKey(toneKey), .toneOut(toneOut), .sendN(sendN)
  );

  function automatic int expHalf(input int tenths);
    real r;
    r = (REF * 10.0) / (2.0 * tenths);
    return int'($floor(r + 0.5));
  endfunction

  function automatic int toneHalf(input int n);
    return expHalf(freqT[n-1]);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input int n, input string req);
    expQ.push_back(n);
    expTag.push_back(req);
  endtask

  // Monitor: measures every half period and compares against the queue
  initial begin
    int cnt = 0;
    logic last = 1'b0;
    forever begin
      @(negedge clk);
      cnt++;
      if (toneOut !== last) begin
        if (expQ.size() > 0) begin
          int e;
          string t;
          e = expQ.pop_front();
          t = expTag.pop_front();
          check(cnt == e, t, cnt, e);
        end
        cnt = 0;
        last = toneOut;
      end
    end
  end

  task automatic sendCode(input int code);
    for (int i = 5; i >= 0; i--) begin
      serData = code[i];
      repeat (2) @(negedge clk);
      serClk = 1'b1;
      repeat (3) @(negedge clk);
      serClk = 1'b0;
      repeat (3) @(negedge clk);
    end
    serLatch = 1'b1;
    repeat (3) @(negedge clk);
    serLatch = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic waitToggle(input string req);
    logic s;
    int n = 0;
    s = toneOut;
    while (toneOut === s && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (toneOut === s) check(1'b0, req, n, -1);
  endtask

  task automatic drain(input string req);
    int n = 0;
    while (expQ.size() != 0 && n < 4000) begin
      @(negedge clk);
      n++;
    end
    check(expQ.size() == 0, req, expQ.size(), 0);
    expQ.delete();
    expTag.delete();
  endtask

  task automatic checkQuiet(input int cycles, input string req);
    int edges = 0;
    logic s;
    s = toneOut;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (toneOut !== s) edges++;
      s = toneOut;
    end
    check(edges == 0 && toneOut == 1'b0, req, edges, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(toneOut == 1'b0, "R8 reset toneOut", toneOut, 0);
    check(sendN == 1'b1, "R8 reset sendN", sendN, 1);

    // R9 / R1: start from stopped state with tone 1
    sendCode(1);
    begin
      int n = 0;
      while (!toneOut && n < toneHalf(1) + 20) begin
        @(negedge clk);
        n++;
      end
      check(toneOut == 1'b1, "R9 start from idle", toneOut, 1);
    end
    waitToggle("R2 toggle");
    @(negedge clk);
    for (int i = 0; i < 4; i++) push(toneHalf(1), "R2 tone1 half");
    drain("R3 tone1 drain");

    // R5: change mid-period, old half finishes at old length
    waitToggle("R5 toggle");
    @(negedge clk);
    push(toneHalf(1), "R5 old half");
    for (int i = 0; i < 3; i++) push(toneHalf(12), "R5 new half");
    sendCode(12);
    drain("R5 drain");

    // R1: MSB first (38 = 100110, reversed would be 25)
    sendCode(38);
    waitToggle("R1 toggle");
    waitToggle("R1 toggle");
    @(negedge clk);
    for (int i = 0; i < 4; i++) push(toneHalf(38), "R1 msb-first tone38");
    drain("R1 drain");

    // R6: burst mode
    toneKey = 1'b1;
    repeat (6) @(negedge clk);
    check(sendN == 1'b0, "R6 sendN low in burst", sendN, 0);
    waitToggle("R6 toggle");
    @(negedge clk);
    for (int i = 0; i < 4; i++) push(expHalf(17500), "R6 burst half");
    drain("R6 drain");

    // R7: tone latched during burst applies at release
    sendCode(12);
    check(sendN == 1'b0, "R6 sendN still low", sendN, 0);
    toneKey = 1'b0;
    repeat (6) @(negedge clk);
    check(sendN == 1'b1, "R6 sendN released", sendN, 1);
    waitToggle("R7 toggle");
    @(negedge clk);
    for (int i = 0; i < 3; i++) push(toneHalf(12), "R7 pending at release");
    drain("R7 drain");

    // R4: invalid tone numbers
    sendCode(0);
    repeat (300) @(negedge clk);
    checkQuiet(700, "R4 code 0 low");
    sendCode(39);
    checkQuiet(700, "R4 code 39 low");
    sendCode(38);
    waitToggle("R9 toggle");
    waitToggle("R9 toggle");
    @(negedge clk);
    for (int i = 0; i < 2; i++) push(toneHalf(38), "R9 restart tone38");
    drain("R9 drain");

    // R8: reset mid-run
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(toneOut == 1'b0, "R8 mid-run toneOut", toneOut, 0);
    check(sendN == 1'b1, "R8 mid-run sendN", sendN, 1);
    rst = 1'b0;
    checkQuiet(600, "R8 tone cleared");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule